// File: doc/BRIEF.md
# MSI Message Ring Buffer Writer

This block gathers message-signalled interrupt writes that arrive as 32-bit data words and turns each one into a 16-byte record placed in a circular buffer in system memory. Software sets the buffer's base address, its size (32 KB to 256 KB), and several enables through a small register port. It then reads entries out of memory at its own pace and advances a read offset.

The block keeps a hardware write offset and a software read offset. Both are multiples of 16 and both wrap inside the buffer. For each accepted message it issues one memory write of a full 16-byte record. The interrupt output stays high while enabled entries remain unread. An optional stop-on-full mode drops messages instead of overwriting unread entries, and records each drop in a sticky status bit.

Both streaming edges use valid/ready. On the inbound message port, a word transfers on a cycle where `msg_valid` and `msg_ready` are both high. `msg_ready` is low while the block is disabled and while a memory write is outstanding, so only one record is in flight at a time. On the outbound memory port, `mem_valid` stays high with address and data held until the cycle where `mem_ready` is high. The register port is plain: a write takes effect at the clock edge where `reg_wr` is high, and `reg_rdata` reflects `reg_addr` combinationally.

Top module: `msg_ring_writer`

## Requirements
- R1: After reset the control readback is 0, the write offset reads 0, `irq` is low, `msg_ready` is low and `mem_valid` is low.
- R2: While the enable bit (control bit 0) is clear, `msg_ready` is low, no memory write is issued and the write offset does not change.
- R3: Each stored message produces one memory write at address base + write offset, where base is {word 3, word 4}. The 128-bit data holds the message word in bits 31:0 (byte 0 in bits 7:0, little-endian) and zeros in bits 127:32.
- R4: Once `mem_valid` rises, address and data stay stable until `mem_ready` is seen, and `msg_ready` stays low for that whole time.
- R5: When a memory write is accepted, the write offset (register 6) advances by 16. It wraps to 0 after the last entry of a buffer of 2^(15+F) bytes, where F is control bits 9:8.
- R6: A write to the read offset (register 5) is stored masked with (2^(15+F) - 1) with bits 3:0 cleared.
- R7: `irq` is high exactly when enable (bit 0) and interrupt enable (bit 3) are both set and the read offset differs from the write offset. Clearing either bit drops `irq`.
- R8: When full detection (bit 1) and stop-on-full (bit 4) are both set and the buffer is full, an incoming message is accepted but not written. The block then sets sticky bit 16 of the control readback. Writing control with bit 16 set clears that bit.
- R9: Without stop-on-full, a message that arrives while the buffer is full is still written and the write offset advances.
- R10: The buffer is full when (write offset + 16), wrapped, equals the read offset. Control readback bit 17 shows this while bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| msg_valid | input | 1 | Inbound message present |
| msg_ready | output | 1 | Block can take a message |
| msg_data | input | 32 | Inbound message word |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | 16-byte record |
| irq | output | 1 | Level interrupt: unread entries |

## Verification
The assertions assume that `mem_ready` eventually answers every request, and that software only moves the read offset to values the block masks itself. They also assume that reset is held for at least one clock before traffic. The bench drives every input at the falling edge and raises `mem_ready` only while `mem_valid` is high. It keeps `msg_valid` high only for single handshakes or for deliberate disabled-port probes, and it reprograms size and offsets only while no record is outstanding.

// File: rtl/msgring_pkg.sv
package msgring_pkg;
  localparam int MSG_W       = 32;
  localparam int ENTRY_BYTES = 16;
  localparam int ENTRY_W     = ENTRY_BYTES * 8;
  localparam int MIN_LOG     = 15;
  localparam int OFF_W       = MIN_LOG + 3;

  typedef enum logic [2:0] {
    RA_CTL    = 3'd0,
    RA_BASE_H = 3'd3,
    RA_BASE_L = 3'd4,
    RA_RDOFF  = 3'd5,
    RA_WROFF  = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] sz;
    logic       stop;
    logic       irq_en;
    logic       full_en;
    logic       en;
  } ctl_t;
endpackage

// File: rtl/msgring_regs.sv
module msgring_regs
  import msgring_pkg::*;
#(
  parameter int W   = MSG_W,
  parameter int OW  = OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [OW-1:0] wr_off,
  input  logic          full,
  input  logic          drop_evt,
  output ctl_t          ctl,
  output logic [2*W-1:0] base,
  output logic [OW-1:0] rd_off,
  output logic [OW-1:0] mask
);
  localparam int STICKY_BIT = 16;
  localparam int FULL_BIT   = 17;

  logic [W-1:0] base_h, base_l;
  logic         dropped;

  always_comb begin
    mask = OW'((OW+1)'(1) << (MIN_LOG + int'(ctl.sz))) - OW'(1);
    mask[3:0] = 4'h0;
  end

  assign base = {base_h, base_l};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= '0;
      base_h  <= '0;
      base_l  <= '0;
      rd_off  <= '0;
      dropped <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_CTL: begin
            ctl.en      <= reg_wdata[0];
            ctl.full_en <= reg_wdata[1];
            ctl.irq_en  <= reg_wdata[3];
            ctl.stop    <= reg_wdata[4];
            ctl.sz      <= reg_wdata[9:8];
          end
          RA_BASE_H: base_h <= reg_wdata;
          RA_BASE_L: base_l <= reg_wdata;
          RA_RDOFF:  rd_off <= reg_wdata[OW-1:0] & mask;
          default: ;
        endcase
      end
      if (drop_evt)
        dropped <= 1'b1;
      else if (reg_wr && reg_addr == RA_CTL && reg_wdata[STICKY_BIT])
        dropped <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTL: begin
        reg_rdata[0]          = ctl.en;
        reg_rdata[1]          = ctl.full_en;
        reg_rdata[3]          = ctl.irq_en;
        reg_rdata[4]          = ctl.stop;
        reg_rdata[9:8]        = ctl.sz;
        reg_rdata[STICKY_BIT] = dropped;
        reg_rdata[FULL_BIT]   = ctl.full_en & full;
      end
      RA_BASE_H: reg_rdata = base_h;
      RA_BASE_L: reg_rdata = base_l;
      RA_RDOFF:  reg_rdata = W'(rd_off);
      RA_WROFF:  reg_rdata = W'(wr_off);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msgring_ptr.sv
module msgring_ptr
  import msgring_pkg::*;
#(
  parameter int OW = OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [OW-1:0] mask,
  input  logic [OW-1:0] rd_off,
  output logic [OW-1:0] wr_off,
  output logic          full,
  output logic          pending
);
  logic [OW-1:0] nxt;

  assign nxt     = (wr_off + OW'(ENTRY_BYTES)) & mask;
  assign full    = (nxt == rd_off);
  assign pending = (wr_off != rd_off);

  always_ff @(posedge clk) begin
    if (!rst_n)   wr_off <= '0;
    else if (adv) wr_off <= nxt;
  end
endmodule

// File: rtl/msgring_emit.sv
module msgring_emit
  import msgring_pkg::*;
#(
  parameter int W  = MSG_W,
  parameter int OW = OFF_W,
  parameter int EW = ENTRY_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           drop_cond,
  input  logic           msg_valid,
  output logic           msg_ready,
  input  logic [W-1:0]   msg_data,
  input  logic [2*W-1:0] base,
  input  logic [OW-1:0]  wr_off,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [2*W-1:0] mem_addr,
  output logic [EW-1:0]  mem_data,
  output logic           adv,
  output logic           drop_evt
);
  logic take;

  assign msg_ready = en & ~mem_valid;
  assign take      = msg_valid & msg_ready;
  assign drop_evt  = take & drop_cond;
  assign adv       = mem_valid & mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (take && !drop_cond) begin
      mem_valid <= 1'b1;
      mem_addr  <= base + {{(2*W-OW){1'b0}}, wr_off};
      mem_data  <= {{(EW-W){1'b0}}, msg_data};
    end else if (adv) begin
      mem_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/msg_ring_writer.sv
module msg_ring_writer
  import msgring_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          msg_valid,
  output logic          msg_ready,
  input  logic [31:0]   msg_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [63:0]   mem_addr,
  output logic [127:0]  mem_data,
  output logic          irq
);
  ctl_t             ctl;
  logic [2*MSG_W-1:0] base;
  logic [OFF_W-1:0] rd_off, wr_off, mask;
  logic             full, pending, adv, drop_evt, ctl_en;

  assign ctl_en = ctl.en;
  assign irq    = ctl.en & ctl.irq_en & pending;

  msgring_regs #(.W(MSG_W), .OW(OFF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_off(wr_off),
    .full(full), .drop_evt(drop_evt), .ctl(ctl), .base(base),
    .rd_off(rd_off), .mask(mask)
  );

  msgring_ptr #(.OW(OFF_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .mask(mask), .rd_off(rd_off),
    .wr_off(wr_off), .full(full), .pending(pending)
  );

  msgring_emit #(.W(MSG_W), .OW(OFF_W), .EW(ENTRY_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .en(ctl.en),
    .drop_cond(ctl.full_en & ctl.stop & full),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
    .base(base), .wr_off(wr_off), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .adv(adv), .drop_evt(drop_evt)
  );
endmodule

// File: rtl/msgring_chk.sv
module msgring_chk #(
  parameter int AW = 64,
  parameter int EW = 128,
  parameter int W  = 32,
  parameter int OW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [EW-1:0] mem_data,
  input logic          irq,
  input logic          ctl_en,
  input logic [OW-1:0] wr_off
);
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !msg_ready);

  a_r3_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_data[EW-1:W] == '0);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !msg_ready);

  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off[3:0] == 4'h0);

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> wr_off != $past(wr_off));

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_en);
endmodule

bind msg_ring_writer msgring_chk #(.AW(64), .EW(128), .W(32), .OW(msgring_pkg::OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_ready(msg_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .irq(irq), .ctl_en(ctl_en), .wr_off(wr_off)
);

// File: tb/msg_ring_writer_test.sv
`timescale 1ns/1ps
module msg_ring_writer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic msg_valid = 1'b0, msg_ready;
  logic [31:0] msg_data = '0;
  logic mem_valid, mem_ready = 1'b0;
  logic [63:0] mem_addr;
  logic [127:0] mem_data;
  logic irq;
  int tests = 0, fails = 0;

  localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;
  localparam logic [35:0] VECS [0:3] = '{
    {4'd0, 32'h0000_0021}, {4'd2, 32'hDEAD_0042},
    {4'd1, 32'h0001_FFFF}, {4'd3, 32'h8000_0007}
  };

  always #5 clk = ~clk;

  msg_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_data(msg_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // handshake one message, then serve the memory write after dly cycles
  task automatic send(input string req, input logic [31:0] d, input int dly,
                      input logic [63:0] exp_addr, input bit check);
    @(negedge clk);
    if (check) chk({req, " ready"}, msg_ready, 1);
    msg_valid = 1'b1; msg_data = d;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
    if (check) begin
      chk({req, " mem_valid"}, mem_valid, 1);
      chk({req, " addr"}, mem_addr, exp_addr);
      chk("R3 data", mem_data, {96'h0, d});
      chk("R4 busy blocks inbound", msg_ready, 0);
    end
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      if (check) chk("R4 hold", {mem_valid, mem_addr}, {1'b1, exp_addr});
    end
    mem_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rreg(3'd0, v); chk("R1 ctl", v, 0);
    rreg(3'd6, v); chk("R1 wroff", v, 0);
    chk("R1 outputs", {irq, msg_ready, mem_valid}, 0);

    // R2 disabled port ignores messages
    msg_valid = 1'b1; msg_data = 32'h55;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 no ready/write", {msg_ready, mem_valid}, 0);
    end
    msg_valid = 1'b0;
    rreg(3'd6, v); chk("R2 wroff", v, 0);

    // program: base, enable + irq enable, size field 1 (64 KB)
    wreg(3'd3, BASE[63:32]);
    wreg(3'd4, BASE[31:0]);
    wreg(3'd0, 32'h109);
    wreg(3'd5, 32'h0001_FFFF);
    rreg(3'd5, v); chk("R6 mask 64K", v, 32'hFFF0);
    wreg(3'd5, 32'h0);

    // vector table
    for (int i = 0; i < 4; i++) begin
      send("R3", VECS[i][31:0], int'(VECS[i][35:32]), BASE + 64'(16*i), 1);
      rreg(3'd6, v); chk("R5 advance", v, 32'(16*(i+1)));
    end
    chk("R7 irq pending", irq, 1);
    wreg(3'd5, 32'h40);
    chk("R7 irq caught up", irq, 0);
    wreg(3'd5, 32'h10);
    chk("R7 irq again", irq, 1);
    wreg(3'd0, 32'h101);
    chk("R7 irq_en clear", irq, 0);

    // R8/R10 stop-on-full, size field 0 (32 KB)
    wreg(3'd0, 32'h1B);
    wreg(3'd5, 32'h50);
    rreg(3'd0, v); chk("R10 full flag", v, 32'h2001B);
    @(negedge clk);
    chk("R8 ready when full", msg_ready, 1);
    msg_valid = 1'b1; msg_data = 32'h99;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
    chk("R8 no write", mem_valid, 0);
    rreg(3'd6, v); chk("R8 wroff kept", v, 32'h40);
    rreg(3'd0, v); chk("R8 sticky", v, 32'h3001B);
    wreg(3'd0, 32'h1001B);
    rreg(3'd0, v); chk("R8 sticky clear", v, 32'h2001B);

    // R9 overwrite without stop
    wreg(3'd0, 32'h0B);
    send("R9", 32'h77, 0, BASE + 64'h40, 1);
    rreg(3'd6, v); chk("R9 wroff", v, 32'h50);
    chk("R7 equal offsets", irq, 0);

    // R5 wrap at 32 KB
    wreg(3'd0, 32'h09);
    wreg(3'd5, 32'h10);
    for (int i = 0; i < 2042; i++) send("R5", 32'(i), 0, 64'h0, 0);
    rreg(3'd6, v); chk("R5 last slot", v, 32'h7FF0);
    send("R5 end", 32'hABCD, 1, BASE + 64'h7FF0, 1);
    rreg(3'd6, v); chk("R5 wrap", v, 0);
    chk("R7 irq after wrap", irq, 1);

    // R7/R2 disable drops irq and ready
    wreg(3'd0, 32'h0);
    chk("R7 disable", {irq, msg_ready}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule